// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block turns 32-bit virtual addresses into 32-bit physical addresses. It holds a small set of entries and searches all of them at once. Each entry names a page whose size is one of nine powers of four, from 4 KB up to 256 MB. Each entry also carries an 8-bit process tag, and a tag of zero makes the entry global. A lookup gives a registered answer one cycle after the request: a hit or a miss, the translated address, and a flag that is set when more than one entry matched.

Software-side logic, outside this block, fills entries one at a time through an indexed write port. It can remove entries in two ways: all at once, or only those that cover a given address. Both removals leave an entry in place when its protect bit is set. Walking page tables, raising faults on a miss, checking permissions and supplying cache attributes all happen outside this block.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_multi` are 0 and `rsp_pa` is 0, so every lookup misses until an entry is written.
- R2: A lookup presented with `lk_req`=1 is answered on the outputs in the following cycle with `rsp_valid`=1. In a cycle after which no lookup was requested, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_multi` are 0.
- R3: A valid entry matches when the virtual address bits at and above its page boundary equal its stored page number. The translated address takes the entry's physical page bits above the boundary and the request's address bits below it.
- R4: Page size code c, from 1 to 9, gives a page of 4^c KB, so address bits [10+2c-1:0] are the page offset. Code 1 is 4 KB and code 9 is 256 MB.
- R5: An entry whose size code is 0 or 10 to 15 never matches.
- R6: An entry matches only when its stored process tag equals `lk_pid`, or when the stored tag is 0, which matches any `lk_pid`.
- R7: For an answered lookup, exactly one of `rsp_hit` and `rsp_miss` is 1. On a miss, `rsp_pa` is 0.
- R8: When two or more entries match, `rsp_hit` and `rsp_multi` are both 1, and `rsp_pa` comes from the matching entry with the lowest index.
- R9: A write loads valid, protect, tag, size code, virtual page and physical page at `wr_idx` on the next clock edge. A lookup presented in the same cycle as the write sees the old contents. Writing valid=0 removes the entry.
- R10: `flush_all` clears the valid bit of every entry whose protect bit is 0, in one cycle. Protected entries keep translating.
- R11: `flush_va_en` clears only unprotected valid entries that match `flush_vpn` and `flush_pid` under the same size-masked, tag-qualified rule as a lookup. This includes global entries.
- R12: When a write and a flush fall in the same cycle, the write is applied after the flush, so the written entry holds its new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Current process tag |
| rsp_valid | output | 1 | A lookup answer is present |
| rsp_hit | output | 1 | The lookup found a matching entry |
| rsp_miss | output | 1 | The lookup found no matching entry |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pa | output | 32 | Translated physical address, 0 on a miss |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 5 | Entry index to load |
| wr_valid | input | 1 | Valid bit to store |
| wr_prot | input | 1 | Protect bit to store |
| wr_pid | input | 8 | Process tag to store, 0 for global |
| wr_size | input | 4 | Page size code to store |
| wr_vpn | input | 20 | Virtual page number, address bits [31:12] |
| wr_ppn | input | 20 | Physical page number, address bits [31:12] |
| flush_all | input | 1 | Invalidate every unprotected entry |
| flush_va_en | input | 1 | Invalidate unprotected entries matching an address |
| flush_vpn | input | 20 | Address bits [31:12] for the address flush |
| flush_pid | input | 8 | Process tag for the address flush |

## Verification
A wrong stored bit only shows up on the first lookup that targets that entry. It then appears one cycle after that request as a wrong hit/miss, a wrong upper address, or a spurious multi-hit. For that reason the bench sweeps every size code with lookups at the page base, at the last byte of the page and one page beyond. It also probes every entry after each flush. Errors in the masking show up as a wrong boundary between hit and miss, or as mixed bits in `rsp_pa` just below the page boundary.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;

    localparam int ADDR_W    = 32;
    localparam int PID_W     = 8;
    localparam int SZ_W      = 4;
    localparam int MIN_SHIFT = 12;
    localparam int PN_W      = ADDR_W - MIN_SHIFT;
    localparam int SZ_LO     = 1;
    localparam int SZ_HI     = 9;

    typedef struct packed {
        logic             valid;
        logic             prot;
        logic [PID_W-1:0] pid;
        logic [SZ_W-1:0]  size;
        logic [PN_W-1:0]  vpn;
        logic [PN_W-1:0]  ppn;
    } ent_t;

    function automatic logic size_ok(input logic [SZ_W-1:0] code);
        return (int'(code) >= SZ_LO) && (int'(code) <= SZ_HI);
    endfunction

    // Page-number bits that take part in the compare for a given size code.
    function automatic logic [PN_W-1:0] pn_keep(input logic [SZ_W-1:0] code);
        logic [PN_W-1:0] m;
        int              ign;
        m = '1;
        if (size_ok(code)) begin
            ign = 2 * int'(code) - 2;
            m   = m << ign;
        end
        return m;
    endfunction

endpackage

// File: rtl/vpage_tlb_cam.sv
module vpage_tlb_cam
    import vpage_tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  ent_t [ENTRIES-1:0] tbl,
    input  logic [PN_W-1:0]    key_pn,
    input  logic [PID_W-1:0]   key_pid,
    output logic [ENTRIES-1:0] match
);

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cell
        logic [PN_W-1:0] keep;
        logic            pn_eq;
        logic            pid_eq;
        assign keep      = pn_keep(tbl[gi].size);
        assign pn_eq     = ((tbl[gi].vpn ^ key_pn) & keep) == '0;
        assign pid_eq    = (tbl[gi].pid == '0) || (tbl[gi].pid == key_pid);
        assign match[gi] = tbl[gi].valid && size_ok(tbl[gi].size) && pn_eq && pid_eq;
    end

endmodule

// File: rtl/vpage_tlb_pick.sv
module vpage_tlb_pick
    import vpage_tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  ent_t [ENTRIES-1:0] tbl,
    input  logic [ENTRIES-1:0] match,
    input  logic [ADDR_W-1:0]  va,
    output logic               hit,
    output logic               multi,
    output logic [ADDR_W-1:0]  pa
);

    logic [IDX_W-1:0] sel;
    ent_t             sel_ent;
    logic [PN_W-1:0]  keep;

    always_comb begin
        hit   = 1'b0;
        multi = 1'b0;
        sel   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                if (hit) begin
                    multi = 1'b1;
                end else begin
                    hit = 1'b1;
                    sel = IDX_W'(i);
                end
            end
        end
    end

    assign sel_ent = tbl[sel];
    assign keep    = pn_keep(sel_ent.size);

    always_comb begin
        if (hit) begin
            pa = {(sel_ent.ppn & keep) | (va[ADDR_W-1:MIN_SHIFT] & ~keep),
                  va[MIN_SHIFT-1:0]};
        end else begin
            pa = '0;
        end
    end

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import vpage_tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_va,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_multi,
    output logic [ADDR_W-1:0] rsp_pa,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_prot,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [PN_W-1:0]   wr_vpn,
    input  logic [PN_W-1:0]   wr_ppn,
    input  logic              flush_all,
    input  logic              flush_va_en,
    input  logic [PN_W-1:0]   flush_vpn,
    input  logic [PID_W-1:0]  flush_pid
);

    typedef struct packed {
        ent_t [ENTRIES-1:0] tbl;
        logic               rv;
        logic               hit;
        logic               miss;
        logic               multi;
        logic [ADDR_W-1:0]  pa;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic               pk_hit;
    logic               pk_multi;
    logic [ADDR_W-1:0]  pk_pa;

    vpage_tlb_cam #(.ENTRIES(ENTRIES)) u_cam_lk (
        .tbl     (st_q.tbl),
        .key_pn  (lk_va[ADDR_W-1:MIN_SHIFT]),
        .key_pid (lk_pid),
        .match   (lk_match)
    );

    vpage_tlb_cam #(.ENTRIES(ENTRIES)) u_cam_fl (
        .tbl     (st_q.tbl),
        .key_pn  (flush_vpn),
        .key_pid (flush_pid),
        .match   (fl_match)
    );

    vpage_tlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .tbl   (st_q.tbl),
        .match (lk_match),
        .va    (lk_va),
        .hit   (pk_hit),
        .multi (pk_multi),
        .pa    (pk_pa)
    );

    always_comb begin
        st_d = st_q;

        st_d.rv    = lk_req;
        st_d.hit   = lk_req & pk_hit;
        st_d.miss  = lk_req & ~pk_hit;
        st_d.multi = lk_req & pk_multi;
        st_d.pa    = lk_req ? pk_pa : '0;

        // Flushes first; a same-cycle write then overrides its slot.
        for (int i = 0; i < ENTRIES; i++) begin
            if (!st_q.tbl[i].prot) begin
                if (flush_all || (flush_va_en && fl_match[i])) begin
                    st_d.tbl[i].valid = 1'b0;
                end
            end
        end

        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            st_d.tbl[wr_idx].valid = wr_valid;
            st_d.tbl[wr_idx].prot  = wr_prot;
            st_d.tbl[wr_idx].pid   = wr_pid;
            st_d.tbl[wr_idx].size  = wr_size;
            st_d.tbl[wr_idx].vpn   = wr_vpn;
            st_d.tbl[wr_idx].ppn   = wr_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.hit;
    assign rsp_miss  = st_q.miss;
    assign rsp_multi = st_q.multi;
    assign rsp_pa    = st_q.pa;

endmodule

// File: rtl/vpage_tlb_chk.sv
module vpage_tlb_chk
    import vpage_tlb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_req,
    input logic [MIN_SHIFT-1:0] lk_off,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rsp_miss,
    input logic                 rsp_multi,
    input logic [ADDR_W-1:0]    rsp_pa
);

    assert_answer_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    assert_no_answer_unasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_multi));

    assert_hit_miss_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    assert_miss_pa_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pa == '0));

    assert_multi_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit);

    assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!rsp_hit || (rsp_pa[MIN_SHIFT-1:0] == $past(lk_off))));

endmodule

bind vpage_tlb vpage_tlb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_off    (lk_va[vpage_tlb_pkg::MIN_SHIFT-1:0]),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_multi (rsp_multi),
    .rsp_pa    (rsp_pa)
);

// File: tb/vpage_tlb_bench.sv
`timescale 1ns/1ps
module vpage_tlb_bench;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_pid = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi;
    logic [31:0] rsp_pa;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_valid = 1'b0, wr_prot = 1'b0;
    logic [7:0]  wr_pid = '0;
    logic [3:0]  wr_size = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic        flush_all = 1'b0, flush_va_en = 1'b0;
    logic [19:0] flush_vpn = '0;
    logic [7:0]  flush_pid = '0;

    int n_chk = 0;
    int n_fail = 0;

    bit          m_v   [N];
    bit          m_p   [N];
    logic [7:0]  m_pid [N];
    logic [3:0]  m_sz  [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_ppn [N];

    always #4 clk = ~clk;

    vpage_tlb u_vpage_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_va(lk_va), .lk_pid(lk_pid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_multi(rsp_multi), .rsp_pa(rsp_pa),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_prot(wr_prot),
        .wr_pid(wr_pid), .wr_size(wr_size), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .flush_all(flush_all), .flush_va_en(flush_va_en),
        .flush_vpn(flush_vpn), .flush_pid(flush_pid)
    );

    function automatic int page_shift(input logic [3:0] code);
        if (code >= 1 && code <= 9) return 10 + 2 * int'(code);
        return 12;
    endfunction

    function automatic bit m_match(input int i, input logic [31:0] va, input logic [7:0] pid);
        int sh;
        if (!m_v[i]) return 1'b0;
        if (m_sz[i] < 1 || m_sz[i] > 9) return 1'b0;
        sh = page_shift(m_sz[i]);
        if ((({m_vpn[i], 12'h000} ^ va) >> sh) != 0) return 1'b0;
        return (m_pid[i] == 8'h00) || (m_pid[i] == pid);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] pid, input string req);
        int          first;
        int          cnt;
        int          sh;
        logic [31:0] mask;
        logic [31:0] epa;
        first = -1;
        cnt   = 0;
        for (int i = 0; i < N; i++) begin
            if (m_match(i, va, pid)) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        epa = '0;
        if (first >= 0) begin
            sh   = page_shift(m_sz[first]);
            mask = 32'hFFFF_FFFF << sh;
            epa  = ({m_ppn[first], 12'h000} & mask) | (va & ~mask);
        end
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_pid = pid;
        @(negedge clk);
        lk_req = 1'b0;
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== (cnt > 0) || rsp_miss !== (cnt == 0) ||
            rsp_multi !== (cnt > 1) || rsp_pa !== epa) begin
            n_fail++;
            $display("FAIL %s va=%h pid=%h: v=%0b hit=%0b miss=%0b multi=%0b pa=%h expected v=1 hit=%0b miss=%0b multi=%0b pa=%h",
                     req, va, pid, rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_pa,
                     cnt > 0, cnt == 0, cnt > 1, epa);
        end
    endtask

    task automatic drive_wr(input int idx, input bit v, input bit p, input logic [7:0] pid,
                            input logic [3:0] sz, input logic [19:0] vpn, input logic [19:0] ppn);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_valid = v; wr_prot = p;
        wr_pid = pid; wr_size = sz; wr_vpn = vpn; wr_ppn = ppn;
    endtask

    task automatic model_wr(input int idx, input bit v, input bit p, input logic [7:0] pid,
                            input logic [3:0] sz, input logic [19:0] vpn, input logic [19:0] ppn);
        m_v[idx] = v; m_p[idx] = p; m_pid[idx] = pid;
        m_sz[idx] = sz; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
    endtask

    task automatic wr(input int idx, input bit v, input bit p, input logic [7:0] pid,
                      input logic [3:0] sz, input logic [19:0] vpn, input logic [19:0] ppn);
        @(negedge clk);
        drive_wr(idx, v, p, pid, sz, vpn, ppn);
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(idx, v, p, pid, sz, vpn, ppn);
    endtask

    task automatic clear_table();
        for (int i = 0; i < N; i++) wr(i, 1'b0, 1'b0, 8'h00, 4'd0, 20'h0, 20'h0);
    endtask

    task automatic do_flush_all();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        for (int i = 0; i < N; i++) if (!m_p[i]) m_v[i] = 1'b0;
    endtask

    task automatic do_flush_addr(input logic [19:0] vpn, input logic [7:0] pid);
        @(negedge clk);
        flush_va_en = 1'b1; flush_vpn = vpn; flush_pid = pid;
        @(negedge clk);
        flush_va_en = 1'b0;
        for (int i = 0; i < N; i++)
            if (!m_p[i] && m_match(i, {vpn, 12'h000}, pid)) m_v[i] = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) model_wr(i, 1'b0, 1'b0, 8'h00, 4'd0, 20'h0, 20'h0);

        // R1: outputs quiet while in reset and table empty afterwards
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        chk(rsp_hit === 1'b0 && rsp_miss === 1'b0, "R1", "hit/miss in reset",
            {30'h0, rsp_hit, rsp_miss}, 32'h0);
        chk(rsp_pa === 32'h0, "R1", "rsp_pa in reset", rsp_pa, 32'h0);
        rst_n = 1'b1;
        lookup(32'h0000_0000, 8'h00, "R1");
        lookup(32'hFFFF_F123, 8'h3A, "R1");

        // R2: no request gives no answer
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R2", "rsp_valid idle", 32'(rsp_valid), 32'h0);

        // R3 R4 R5: sweep every size code at base, last byte, next page
        for (int c = 0; c < 16; c++) begin
            int          sh;
            logic [31:0] base;
            string       tag;
            tag  = (c >= 1 && c <= 9) ? "R4" : "R5";
            sh   = page_shift(4'(c));
            base = {20'hA5A5A, 12'h000} & (32'hFFFF_FFFF << sh);
            wr(0, 1'b1, 1'b0, 8'h00, 4'(c), base[31:12], 20'h3C3C3);
            lookup(base, 8'h11, tag);
            lookup(base | ((32'h1 << sh) - 32'h1), 8'h11, "R3");
            lookup(base ^ (32'h1 << sh), 8'h11, tag);
        end

        // R6: process tag match and global entries
        wr(0, 1'b0, 1'b0, 8'h00, 4'd0, 20'h0, 20'h0);
        wr(1, 1'b1, 1'b0, 8'h05, 4'd1, 20'h11111, 20'h22222);
        lookup(32'h1111_1ABC, 8'h05, "R6");
        lookup(32'h1111_1ABC, 8'h06, "R6");
        wr(2, 1'b1, 1'b0, 8'h00, 4'd2, 20'h40000, 20'h50000);
        lookup(32'h4000_2345, 8'h77, "R6");
        lookup(32'h4000_2345, 8'h00, "R6");

        // R8: overlapping entries, lowest index supplies the address
        wr(3, 1'b1, 1'b0, 8'h00, 4'd3, 20'h80000, 20'h90000);
        wr(7, 1'b1, 1'b0, 8'h00, 4'd5, 20'h80000, 20'hA0000);
        lookup(32'h8000_1234, 8'h09, "R8");
        lookup(32'h8004_0000, 8'h09, "R8");

        // R9: lookup in the write cycle sees the old contents
        @(negedge clk);
        drive_wr(12, 1'b1, 1'b0, 8'h00, 4'd1, 20'hC0000, 20'hD0000);
        lk_req = 1'b1; lk_va = 32'hC000_0010; lk_pid = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        chk(rsp_valid === 1'b1 && rsp_miss === 1'b1 && rsp_hit === 1'b0, "R9",
            "same-cycle lookup", {30'h0, rsp_hit, rsp_miss}, 32'h1);
        model_wr(12, 1'b1, 1'b0, 8'h00, 4'd1, 20'hC0000, 20'hD0000);
        lookup(32'hC000_0010, 8'h00, "R9");
        wr(12, 1'b0, 1'b0, 8'h00, 4'd1, 20'hC0000, 20'hD0000);
        lookup(32'hC000_0010, 8'h00, "R9");

        // R10: invalidate-all spares protected entries
        for (int i = 0; i < N; i++)
            wr(i, 1'b1, (i % 3) == 0, 8'h00, 4'd1, 20'h01000 + 20'(i), 20'h70000 + 20'(i));
        do_flush_all();
        for (int i = 0; i < N; i++) lookup({20'h01000 + 20'(i), 12'h0F0}, 8'h21, "R10");

        // R11: invalidate by address, size-masked and tag-qualified
        clear_table();
        wr(0, 1'b1, 1'b0, 8'h04, 4'd2, 20'h20000, 20'h60000);
        wr(1, 1'b1, 1'b1, 8'h04, 4'd2, 20'h20000, 20'h61000);
        wr(2, 1'b1, 1'b0, 8'h09, 4'd2, 20'h20000, 20'h62000);
        wr(3, 1'b1, 1'b0, 8'h00, 4'd2, 20'h20030, 20'h63000);
        wr(4, 1'b1, 1'b0, 8'h00, 4'd4, 20'h20000, 20'h64000);
        do_flush_addr(20'h20001, 8'h04);
        lookup(32'h2000_0100, 8'h04, "R11");
        lookup(32'h2000_0100, 8'h09, "R11");
        lookup(32'h2003_0100, 8'h04, "R11");
        lookup(32'h2003_F000, 8'h55, "R11");

        // R12: write and flush in the same cycle, write wins
        @(negedge clk);
        flush_all = 1'b1;
        drive_wr(10, 1'b1, 1'b0, 8'h00, 4'd1, 20'hE0000, 20'hF0000);
        @(negedge clk);
        flush_all = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < N; i++) if (!m_p[i]) m_v[i] = 1'b0;
        model_wr(10, 1'b1, 1'b0, 8'h00, 4'd1, 20'hE0000, 20'hF0000);
        lookup(32'hE000_0ABC, 8'h01, "R12");
        lookup(32'h2000_0100, 8'h04, "R12");

        summary();
        $finish;
    end

endmodule